// File: doc/BRIEF.md
# Serial Interrupt Bus Arbitration Unit

Each agent on a shared two-wire synchronous interrupt message bus holds one copy of this unit. When its message sender raises a request and no slot is in progress, the unit opens a slot with a start cycle. In that cycle wire 0 is high and wire 1 carries the priority class. In the next four cycles it places its 4-bit arbitration ID on wire 1, most significant bit first. The wires resolve as a wired-OR of all active drivers. Any agent that drove a 0 on wire 1 but sees a 1 there has lost. It raises a one-cycle lose indication and stays silent for the rest of the slot. Each later cycle breaks the tie left by the cycles before it.

Every unit follows the slot by watching the bus: a high wire 0 while the bus is idle marks a start cycle. The slot then covers the four ID cycles and a fixed number of message cycles, during which no agent may open a new slot. The single agent still contending after the last ID cycle gets a one-cycle grant and may use the message cycles. An agent that lost keeps its request and competes again when the bus next goes idle.

Top module: `irq_bus_arbiter`

## Requirements
- R1: With the request high and no slot in progress, the unit drives a start cycle in that same cycle. Wire 0 is 1 and wire 1 equals the priority input (1 = EOI class, 0 = normal class). Every requesting agent on an idle bus starts in the same cycle, and no start is driven while a slot is in progress.
- R2: In slot cycles 2, 3, 4 and 5, a still-contending agent drives ID bit 3, 2, 1 and 0 on wire 1, in that order, and drives wire 0 low.
- R3: An agent loses in the cycle where it drives wire 1 low but samples it high. Lose is high in that very cycle, and the agent drives neither wire for the rest of the slot.
- R4: Any EOI-class request beats every normal-class request in the same slot. This is resolved in the start cycle.
- R5: Among the best class present, the agent with the highest ID wins, and exactly one agent is granted per slot.
- R6: Grant is a single-cycle pulse in slot cycle 6, the cycle after the last ID cycle. It is never raised together with lose, and it is raised at most once per slot.
- R7: A slot lasts 4 + 1 + MSG_CYCLES cycles (11 by default). No agent drives wire 0 after the start cycle of the slot. A request that rises during a slot waits for the next idle cycle.
- R8: A losing agent whose request stays high competes again in the first idle cycle after the slot ends, with no other action needed.
- R9: While reset is asserted, both drive outputs, grant and lose are low, even with the request high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Message pending from the sender |
| eoi_pri_i | input | 1 | Priority class of the pending message, 1 = EOI |
| agent_id_i | input | ID_W | Arbitration ID of this agent |
| drv_b1_o | output | 1 | Drive request for wire 1 (wired-OR outside) |
| drv_b0_o | output | 1 | Drive request for wire 0 (wired-OR outside) |
| bus_b1_i | input | 1 | Resolved value of wire 1 |
| bus_b0_i | input | 1 | Resolved value of wire 0 |
| grant_o | output | 1 | One-cycle pulse: this agent won the slot |
| lose_o | output | 1 | One-cycle pulse: this agent dropped off |

## Verification
Several properties are checked on every cycle:
- a start is driven only on an idle bus, and every start is followed by slot phase 1;
- the slot phase stays in range, and wire 0 stays low inside a slot;
- a loser is silent from the next cycle on;
- grant appears only in the cycle after the last ID cycle, is a single-cycle pulse, and never coincides with lose.

Whether the right agent won cannot be seen by one unit alone. The same holds for the exact cycle of each loss, for EOI requests outranking normal ones, and for losers coming back in the next slot. Only the bench's scenarios show these, because it runs four agents on a shared wired-OR bus and compares them with its own priority model.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;

  // Resolved pair of bus wires as seen or driven by one agent.
  typedef struct packed {
    logic b1;
    logic b0;
  } wire_pair_t;

  // An agent is beaten on a wired-OR wire when it left the wire low
  // and somebody else pulled it high.
  function automatic logic beaten_on_wire(input logic driven, input logic seen);
    return (!driven) && seen;
  endfunction

  // Which bit of a serial ID is on the wire in a given ID phase.
  // Phase 1 carries the top bit, phase id_width the bottom bit.
  function automatic int id_bit_index(input int id_width, input int phase);
    return id_width - phase;
  endfunction

endpackage

// File: rtl/irqarb_slot_tracker.sv
module irqarb_slot_tracker #(
  parameter int ID_W       = 4,
  parameter int MSG_CYCLES = 6,
  parameter int PH_W       = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_b0_i,
  output logic            in_slot_o,
  output logic [PH_W-1:0] phase_o,
  output logic            slot_start_o,
  output logic            arb_phase_o,
  output logic            last_id_o,
  output logic            grant_phase_o
);

  localparam int LAST_PHASE = ID_W + MSG_CYCLES;

  logic            in_slot_q;
  logic [PH_W-1:0] phase_q;

  // A high wire 0 on an idle bus is a start cycle for every observer.
  assign slot_start_o  = !in_slot_q && bus_b0_i;
  assign arb_phase_o   = in_slot_q && (phase_q >= PH_W'(1)) && (phase_q <= PH_W'(ID_W));
  assign last_id_o     = in_slot_q && (phase_q == PH_W'(ID_W));
  assign grant_phase_o = in_slot_q && (phase_q == PH_W'(ID_W + 1));
  assign in_slot_o     = in_slot_q;
  assign phase_o       = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_slot_q <= 1'b0;
      phase_q   <= '0;
    end else if (slot_start_o) begin
      in_slot_q <= 1'b1;
      phase_q   <= PH_W'(1);
    end else if (in_slot_q) begin
      if (phase_q == PH_W'(LAST_PHASE)) begin
        in_slot_q <= 1'b0;
        phase_q   <= '0;
      end else begin
        phase_q <= phase_q + PH_W'(1);
      end
    end
  end

  // R7: the phase count stays inside the slot length.
  a_r7_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    in_slot_q |-> (phase_q >= PH_W'(1)) && (phase_q <= PH_W'(LAST_PHASE)));

  // R7: nobody on the bus opens a start cycle inside a running slot.
  a_r7_no_start_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    in_slot_q |-> !bus_b0_i);

endmodule

// File: rtl/irqarb_contender.sv
module irqarb_contender
  import irqarb_pkg::*;
#(
  parameter int ID_W = 4,
  parameter int PH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_i,
  input  logic            eoi_pri_i,
  input  logic [ID_W-1:0] agent_id_i,
  input  logic            in_slot_i,
  input  logic [PH_W-1:0] phase_i,
  input  logic            arb_phase_i,
  input  logic            last_id_i,
  input  logic            grant_phase_i,
  input  logic            bus_b1_i,
  output wire_pair_t      drive_o,
  output logic            lose_o,
  output logic            grant_o
);

  logic in_arb_q, in_arb_d;
  logic grant_q, grant_d;
  logic start_drive, arb_drive, id_bit, b1_drive, lost_now;

  function automatic logic serial_bit(input logic [ID_W-1:0] id, input logic [PH_W-1:0] ph);
    int idx;
    idx = id_bit_index(ID_W, int'(ph));
    if (idx < 0 || idx >= ID_W) return 1'b0;
    return id[idx];
  endfunction

  assign start_drive = rst_n && req_i && !in_slot_i;
  assign arb_drive   = arb_phase_i && in_arb_q;
  assign id_bit      = serial_bit(agent_id_i, phase_i);

  always_comb begin
    if (start_drive)    b1_drive = eoi_pri_i;
    else if (arb_drive) b1_drive = id_bit;
    else                b1_drive = 1'b0;
  end

  assign lost_now = (start_drive || arb_drive) && beaten_on_wire(b1_drive, bus_b1_i);

  always_comb begin
    in_arb_d = 1'b0;
    grant_d  = 1'b0;
    if (start_drive) begin
      in_arb_d = !lost_now;
    end else if (arb_drive) begin
      in_arb_d = !lost_now && !last_id_i;
      grant_d  = !lost_now && last_id_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_arb_q <= 1'b0;
      grant_q  <= 1'b0;
    end else begin
      in_arb_q <= in_arb_d;
      grant_q  <= grant_d;
    end
  end

  assign drive_o.b1 = b1_drive;
  assign drive_o.b0 = start_drive;
  assign lose_o     = lost_now;
  assign grant_o    = grant_q;

  // R1: a start is only driven while the tracker reports an idle bus.
  a_r1_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    drive_o.b0 |-> !in_slot_i);

  // R2: wire 0 is left low during the ID cycles.
  a_r2_b0_low_in_id: assert property (@(posedge clk) disable iff (!rst_n)
    arb_phase_i |-> !drive_o.b0);

  // R3: once dropped off, the agent stays silent on the following cycle.
  a_r3_silent_after_loss: assert property (@(posedge clk) disable iff (!rst_n)
    lose_o |=> !drive_o.b1 && !drive_o.b0);

  // R6: grant lands in the cycle after the last ID cycle.
  a_r6_grant_in_grant_phase: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> grant_phase_i);

  // R6: grant is a one-cycle pulse.
  a_r6_grant_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |=> !grant_o);

  // R6: grant and lose never together.
  a_r6_no_grant_and_lose: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_o && lose_o));

endmodule

// File: rtl/irq_bus_arbiter.sv
module irq_bus_arbiter
  import irqarb_pkg::*;
#(
  parameter int ID_W       = 4,
  parameter int MSG_CYCLES = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_i,
  input  logic            eoi_pri_i,
  input  logic [ID_W-1:0] agent_id_i,
  output logic            drv_b1_o,
  output logic            drv_b0_o,
  input  logic            bus_b1_i,
  input  logic            bus_b0_i,
  output logic            grant_o,
  output logic            lose_o
);

  localparam int SLOT_LEN = ID_W + 1 + MSG_CYCLES;
  localparam int PH_W     = $clog2(SLOT_LEN);

  logic            in_slot;
  logic [PH_W-1:0] phase;
  logic            slot_start;
  logic            arb_phase;
  logic            last_id;
  logic            grant_phase;
  wire_pair_t      drive;

  irqarb_slot_tracker #(
    .ID_W(ID_W), .MSG_CYCLES(MSG_CYCLES), .PH_W(PH_W)
  ) u_tracker (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_b0_i      (bus_b0_i),
    .in_slot_o     (in_slot),
    .phase_o       (phase),
    .slot_start_o  (slot_start),
    .arb_phase_o   (arb_phase),
    .last_id_o     (last_id),
    .grant_phase_o (grant_phase)
  );

  irqarb_contender #(
    .ID_W(ID_W), .PH_W(PH_W)
  ) u_contender (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req_i),
    .eoi_pri_i     (eoi_pri_i),
    .agent_id_i    (agent_id_i),
    .in_slot_i     (in_slot),
    .phase_i       (phase),
    .arb_phase_i   (arb_phase),
    .last_id_i     (last_id),
    .grant_phase_i (grant_phase),
    .bus_b1_i      (bus_b1_i),
    .drive_o       (drive),
    .lose_o        (lose_o),
    .grant_o       (grant_o)
  );

  assign drv_b1_o = drive.b1;
  assign drv_b0_o = drive.b0;

  // R1: an own start cycle moves the tracker to phase 1.
  a_r1_start_opens_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_b0_o && bus_b0_i) |=> in_slot && (phase == PH_W'(1)));

  // R9: outputs quiet during reset (immediate check).
  always_comb begin
    if (!rst_n) begin
      a_r9_quiet_in_reset: assert (!drv_b0_o && !drv_b1_o && !lose_o);
    end
  end

  logic unused_slot_start;
  assign unused_slot_start = slot_start;

endmodule

// File: tb/tb_irq_bus_arbiter.sv
module tb_irq_bus_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 4;
  localparam int ID_W       = 4;
  localparam int MSG        = 6;
  localparam int SLOT_LEN   = ID_W + 1 + MSG;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    req = '0;
  logic [N-1:0]    eoi = '0;
  logic [ID_W-1:0] ids [N];
  logic [N-1:0]    d1, d0, gnt, lse;
  wire             b1 = |d1;
  wire             b0 = |d0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : g_agent
    irq_bus_arbiter #(.ID_W(ID_W), .MSG_CYCLES(MSG)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req[g]),
      .eoi_pri_i  (eoi[g]),
      .agent_id_i (ids[g]),
      .drv_b1_o   (d1[g]),
      .drv_b0_o   (d0[g]),
      .bus_b1_i   (b1),
      .bus_b0_i   (b0),
      .grant_o    (gnt[g]),
      .lose_o     (lse[g])
    );
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // Bench model: best class present, then highest ID inside it.
  function automatic int pick_winner(input logic [N-1:0] m);
    int best = -1;
    logic top_cls = |(m & eoi);
    for (int i = 0; i < N; i++)
      if (m[i] && (eoi[i] == top_cls) && (best < 0 || ids[i] > ids[best])) best = i;
    return best;
  endfunction

  // A loser drops at the first serial position where it differs from the winner.
  function automatic int drop_cycle(input int a, input int w);
    if (eoi[a] != eoi[w]) return 1;
    for (int k = ID_W - 1; k >= 0; k--)
      if (ids[a][k] != ids[w][k]) return 1 + (ID_W - k);
    return -1;
  endfunction

  task automatic run_slot(input string tag, input int late_agent, input int late_cycle);
    logic [N-1:0] m;
    int c, win, gcount, gcycle, gwho, waited, pat_bad, b0_bad, extra_lose;
    int lc [N];
    gcount = 0; gcycle = -1; gwho = -1; pat_bad = 0; b0_bad = 0; extra_lose = 0; waited = 0;
    for (int i = 0; i < N; i++) lc[i] = 0;
    do begin
      @(negedge clk); #1;
      waited++;
    end while (!b0 && waited < 30);
    chk(b0 == 1'b1, {"R1 start seen ", tag}, b0, 1);
    m   = req;
    win = pick_winner(m);
    chk(d0 == m, {"R1 all requesters start ", tag}, d0, m);
    c = 1;
    while (1) begin
      for (int a = 0; a < N; a++) begin
        if (lse[a]) begin
          if (lc[a] == 0) lc[a] = c;
          else extra_lose++;
        end
        if (gnt[a]) begin
          gcount++; gwho = a; gcycle = c; req[a] = 1'b0;
        end
      end
      if (win >= 0) begin
        if (c == 1) begin
          if (!(d0[win] && d1[win] == eoi[win])) pat_bad++;
        end else if (c <= ID_W + 1) begin
          if (!(!d0[win] && d1[win] == ids[win][ID_W + 1 - c])) pat_bad++;
        end else if (d0[win] || d1[win]) pat_bad++;
      end
      if (c > 1 && b0) b0_bad++;
      if (c == late_cycle && late_agent >= 0) req[late_agent] = 1'b1;
      if (c == SLOT_LEN) break;
      @(negedge clk); #1;
      c++;
    end
    chk(gcount == 1, {"R5 one grant ", tag}, gcount, 1);
    chk(gwho == win, {"R4/R5 winner ", tag}, gwho, win);
    chk(gcycle == ID_W + 2, {"R6 grant cycle ", tag}, gcycle, ID_W + 2);
    chk(pat_bad == 0, {"R2 winner drive pattern ", tag}, pat_bad, 0);
    chk(b0_bad == 0, {"R7 no start inside slot ", tag}, b0_bad, 0);
    chk(extra_lose == 0, {"R3 single lose pulse ", tag}, extra_lose, 0);
    for (int a = 0; a < N; a++) begin
      if (m[a] && a != win)
        chk(lc[a] == drop_cycle(a, win), {"R3 drop cycle ", tag}, lc[a], drop_cycle(a, win));
      else
        chk(lc[a] == 0, {"R3 no lose for non-loser ", tag}, lc[a], 0);
    end
  endtask

  task automatic t_reset();
    req = '1; eoi = '0;
    repeat (3) @(negedge clk);
    #1;
    chk({d0, d1, gnt, lse} == '0, "R9 quiet in reset", {d0, d1, gnt, lse}, 0);
    req = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk({d0, d1, gnt, lse} == '0, "R9 quiet after reset", {d0, d1, gnt, lse}, 0);
  endtask

  task automatic t_single();
    ids[0] = 4'd3; ids[1] = 4'd9; ids[2] = 4'd5; ids[3] = 4'd12;
    eoi = '0; req = 4'b0100;
    run_slot("single", -1, 0);
  endtask

  task automatic t_normal_sweep();
    eoi = '0; req = 4'b1111;
    run_slot("normal s1", -1, 0);   // id 12
    run_slot("normal s2 R8", -1, 0); // id 9 retry
    run_slot("normal s3 R8", -1, 0); // id 5
    run_slot("normal s4 R8", -1, 0); // id 3
  endtask

  task automatic t_eoi_mix();
    eoi = 4'b0011; req = 4'b1111;
    run_slot("eoi s1 R4", -1, 0);   // agent 1 (eoi, 9)
    run_slot("eoi s2 R4", -1, 0);   // agent 0 (eoi, 3)
    run_slot("eoi s3", -1, 0);      // agent 3
    run_slot("eoi s4", -1, 0);      // agent 2
  endtask

  task automatic t_extreme_ids();
    ids[0] = 4'd0; ids[1] = 4'd15; ids[2] = 4'd8; ids[3] = 4'd7;
    eoi = '0; req = 4'b1111;
    run_slot("extreme s1", -1, 0);
    run_slot("extreme s2", -1, 0);
    run_slot("extreme s3", -1, 0);
    run_slot("extreme s4", -1, 0);
  endtask

  task automatic t_late_request();
    ids[0] = 4'd10; ids[1] = 4'd1; ids[2] = 4'd6; ids[3] = 4'd4;
    eoi = '0; req = 4'b0010;
    run_slot("late s1 R7", 3, 3);
    run_slot("late s2 R7", -1, 0);  // agent 3 starts only now
  endtask

  initial begin
    ids[0] = '0; ids[1] = '0; ids[2] = '0; ids[3] = '0;
    t_reset();
    t_single();
    t_normal_sweep();
    t_eoi_mix();
    t_extreme_ids();
    t_late_request();
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog all actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule